// File: doc/BRIEF.md
# CPU Interrupt and Reset Sequencer

This block sits beside the instruction engine of an 8-bit processor whose stack lives in a single 256-byte page. It keeps a bitmask of interrupt requests. One bit is the non-maskable source, some bits are one-shot, and the rest are level sources. At each instruction boundary it decides whether to enter the reset, non-maskable or maskable service sequence. While a sequence runs it drives the memory bus itself. It pushes the return address and status onto the stack page and reads the two-byte service vector. It then presents the new program counter, status and stack pointer.

After reset is released the block reads the reset vector at once. During that time `busy` is high, which holds the instruction engine off fetching. The memory bus is a request stream. A request is presented with `bus_valid` and is accepted in a cycle where `bus_ready` is also high. For reads, `bus_rdata` must be valid in that same accepting cycle. While `bus_ready` is low the request is back-pressured: address, direction and write data stay frozen and the sequence does not advance. All other pins are plain control and status signals.

Top module: `int_seq_top`

## Requirements
- R1: After reset is released, `busy` is high and the block reads 0xFFFC and then 0xFFFD. It then pulses `done` together with `jam_clr`. At that point `pc_out` = {byte from 0xFFFD, byte from 0xFFFC}, `p_out` = 0x04 (only the I flag, bit 2) and `s_out` = `s_in`.
- R2: Each pending bit is set by its `irq_set` bit and cleared by its `irq_clr` bit, and each bit works independently of the others. `irq_line` is high whenever any pending bit is set.
- R3: At an evaluation with the non-maskable bit pending, the non-maskable sequence runs and reads 0xFFFA and then 0xFFFB. This happens regardless of `i_prev` and of any other pending bits.
- R4: With no non-maskable bit pending, a maskable sequence starts only if `i_prev` = 0 and `jammed` = 0. Otherwise `busy` and `bus_valid` stay low.
- R5: A pending non-maskable request is not serviced while `jammed` = 1.
- R6: Every evaluation clears the non-maskable bit and the one-shot bits, whether or not a sequence starts. Level bits remain set.
- R7: A service sequence writes three bytes. First PC[15:8] goes to {0x01, S}, then PC[7:0] to {0x01, S-1}, then status to {0x01, S-2}. The status byte is P with bit 4 cleared and bit 5 set. S wraps modulo 256, and `s_out` = S-3.
- R8: After the pushes, the block reads the vector low byte and then the high byte. The maskable vector is at 0xFFFE/0xFFFF. `pc_out` = {high, low}. `p_out` is P with bit 4 cleared, with bit 2 also set on the maskable path only.
- R9: With `bus_ready` held high, `busy` stays high for exactly 7 cycles, and the first two of them carry no bus request. `done` is a one-cycle pulse in the first cycle after `busy` falls.
- R10: While `bus_valid` is high and `bus_ready` is low, the request stays unchanged and the sequence does not advance. Each stalled cycle lengthens the sequence by one cycle.
- R11: An evaluation happens only in a cycle with `boundary` = 1 and `busy` = 0, and only when some bit is pending. A `boundary` pulse during a sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; release starts the reset sequence |
| irq_set | input | NSRC | Per-source set pulses |
| irq_clr | input | NSRC | Per-source clear pulses |
| boundary | input | 1 | Instruction-boundary strobe |
| i_prev | input | 1 | I flag as it stood before the last instruction |
| jammed | input | 1 | Processor is halted in a jam state |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status register |
| s_in | input | 8 | Current stack pointer |
| irq_line | output | 1 | Any source pending |
| busy | output | 1 | Sequence in progress; fetch must wait |
| done | output | 1 | One-cycle pulse: new PC, P and S are valid |
| jam_clr | output | 1 | Pulses with `done` at the end of reset |
| pc_out | output | 16 | New program counter |
| p_out | output | 8 | New status register |
| s_out | output | 8 | New stack pointer |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts the request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the accepting cycle |

## Verification
The bench builds the block with four sources. Bit 3 is the non-maskable source, bit 2 is one-shot, and bits 0 and 1 are level sources. This mix allows each evaluation outcome to be tested: priority of the non-maskable bit over a level bit, a one-shot request dropped under the mask, and a level request that persists after service. The default seven-cycle service length is kept. Stack pointers of 0x01 and 0x00 push across the page wrap. A bus that refuses every request once shows that stalls freeze the request and lengthen the sequence.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_LO,
    ST_RST_HI,
    ST_WAIT,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_ST,
    ST_VEC_LO,
    ST_VEC_HI
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_RESET,
    SRC_NMI,
    SRC_IRQ
  } svc_kind_e;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;

  localparam logic [15:0] VEC_NMI_ADDR = 16'hFFFA;
  localparam logic [15:0] VEC_RST_ADDR = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ_ADDR = 16'hFFFE;

  localparam int BUS_STEPS = 5;

  function automatic logic [15:0] vec_base(input svc_kind_e k);
    case (k)
      SRC_NMI: return VEC_NMI_ADDR;
      SRC_IRQ: return VEC_IRQ_ADDR;
      default: return VEC_RST_ADDR;
    endcase
  endfunction

  function automatic logic is_bus_state(input seq_state_e s);
    return (s == ST_RST_LO) || (s == ST_RST_HI) || (s == ST_PUSH_HI) ||
           (s == ST_PUSH_LO) || (s == ST_PUSH_ST) || (s == ST_VEC_LO) ||
           (s == ST_VEC_HI);
  endfunction

  function automatic logic is_push_state(input seq_state_e s);
    return (s == ST_PUSH_HI) || (s == ST_PUSH_LO) || (s == ST_PUSH_ST);
  endfunction

endpackage

// File: rtl/int_pend_track.sv
module int_pend_track #(
  parameter int NSRC = 4,
  parameter int NMI_BIT = 0,
  parameter logic [NSRC-1:0] ONESHOT_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic            eval_en,
  input  logic            i_prev,
  input  logic            jammed,
  output logic            line,
  output logic            take,
  output logic            take_nmi
);

  localparam logic [NSRC-1:0] NMI_ONEHOT = {{(NSRC-1){1'b0}}, 1'b1} << NMI_BIT;
  localparam logic [NSRC-1:0] DROP_MASK  = NMI_ONEHOT | ONESHOT_MASK;

  logic [NSRC-1:0] pend;
  logic            evaluating;
  logic            nmi_pend;

  assign line       = |pend;
  assign nmi_pend   = pend[NMI_BIT];
  assign evaluating = eval_en & line;
  assign take_nmi   = nmi_pend;
  assign take       = evaluating & ~jammed & (nmi_pend | ~i_prev);

  // One flop per source; a set in the same cycle wins over any clear.
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
      end else begin
        pend[g] <= src_set[g] |
                   (pend[g] & ~src_clr[g] & ~(evaluating & DROP_MASK[g]));
      end
    end
  end

  // R6: an evaluation drops the non-maskable and one-shot bits
  a_r6_drop_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
    evaluating |=> ((pend & DROP_MASK & ~$past(src_set)) == '0));

  // R2: a set request is visible in the following cycle
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((pend & $past(src_set)) == $past(src_set)));

endmodule

// File: rtl/int_seq_ctrl.sv
module int_seq_ctrl
  import int_seq_pkg::*;
#(
  parameter int SVC_CYCLES = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_nmi,
  input  logic       bus_fire,
  output seq_state_e state,
  output svc_kind_e  kind,
  output logic       busy,
  output logic       done
);

  localparam int WAIT_CYC = SVC_CYCLES - BUS_STEPS;
  localparam int CW       = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  logic [CW-1:0] wait_cnt;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RST_LO;
      kind     <= SRC_RESET;
      wait_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            kind     <= take_nmi ? SRC_NMI : SRC_IRQ;
            wait_cnt <= CW'(WAIT_CYC - 1);
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wait_cnt == '0) state <= ST_PUSH_HI;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        ST_RST_LO:  if (bus_fire) state <= ST_RST_HI;
        ST_RST_HI:  if (bus_fire) begin state <= ST_IDLE; done <= 1'b1; end
        ST_PUSH_HI: if (bus_fire) state <= ST_PUSH_LO;
        ST_PUSH_LO: if (bus_fire) state <= ST_PUSH_ST;
        ST_PUSH_ST: if (bus_fire) state <= ST_VEC_LO;
        ST_VEC_LO:  if (bus_fire) state <= ST_VEC_HI;
        ST_VEC_HI:  if (bus_fire) begin state <= ST_IDLE; done <= 1'b1; end
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // R9: done is a single pulse that follows the end of a busy stretch
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/int_frame_path.sv
module int_frame_path
  import int_seq_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  seq_state_e  state,
  input  svc_kind_e   kind,
  input  logic        capture,
  input  logic        bus_fire,
  input  logic [15:0] pc_in,
  input  logic [7:0]  p_in,
  input  logic [7:0]  s_in,
  input  logic [7:0]  bus_rdata,
  output logic [15:0] bus_addr,
  output logic        bus_we,
  output logic [7:0]  bus_wdata,
  output logic [15:0] pc_out,
  output logic [7:0]  p_out,
  output logic [7:0]  s_out
);

  logic [15:0] pc_q;
  logic [7:0]  p_q;
  logic [7:0]  sp;
  logic [7:0]  vec_lo;
  logic [7:0]  st_pushed;
  logic [7:0]  p_next;
  logic        hi_step;

  assign st_pushed = (p_q & ~(8'h1 << FLAG_B)) | (8'h1 << FLAG_U);
  assign hi_step   = (state == ST_VEC_HI) || (state == ST_RST_HI);

  always_comb begin
    bus_we    = is_push_state(state);
    bus_addr  = vec_base(kind) + {15'b0, hi_step};
    bus_wdata = 8'h00;
    if (is_push_state(state)) bus_addr = {STACK_PAGE, sp};
    case (state)
      ST_PUSH_HI: bus_wdata = pc_q[15:8];
      ST_PUSH_LO: bus_wdata = pc_q[7:0];
      ST_PUSH_ST: bus_wdata = st_pushed;
      default:    bus_wdata = 8'h00;
    endcase
  end

  always_comb begin
    p_next = p_q & ~(8'h1 << FLAG_B);
    if (kind == SRC_IRQ)   p_next = p_next | (8'h1 << FLAG_I);
    if (kind == SRC_RESET) p_next = 8'h1 << FLAG_I;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      p_q    <= '0;
      sp     <= '0;
      vec_lo <= '0;
      pc_out <= '0;
      p_out  <= '0;
      s_out  <= '0;
    end else begin
      if (capture) begin
        pc_q <= pc_in;
        p_q  <= p_in;
        sp   <= s_in;
      end
      if (bus_fire) begin
        if (is_push_state(state)) sp <= sp - 8'd1;
        if ((state == ST_VEC_LO) || (state == ST_RST_LO)) vec_lo <= bus_rdata;
        if (hi_step) begin
          pc_out <= {bus_rdata, vec_lo};
          p_out  <= p_next;
          s_out  <= (kind == SRC_RESET) ? s_in : sp;
        end
      end
    end
  end

endmodule

// File: rtl/int_seq_top.sv
module int_seq_top
  import int_seq_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NMI_BIT = 0,
  parameter logic [NSRC-1:0] ONESHOT_MASK = 4'b0010,
  parameter int SVC_CYCLES = 7,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_set,
  input  logic [NSRC-1:0] irq_clr,
  input  logic            boundary,
  input  logic            i_prev,
  input  logic            jammed,
  input  logic [15:0]     pc_in,
  input  logic [7:0]      p_in,
  input  logic [7:0]      s_in,
  output logic            irq_line,
  output logic            busy,
  output logic            done,
  output logic            jam_clr,
  output logic [15:0]     pc_out,
  output logic [7:0]      p_out,
  output logic [7:0]      s_out,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic            bus_we,
  output logic [15:0]     bus_addr,
  output logic [7:0]      bus_wdata,
  input  logic [7:0]      bus_rdata
);

  seq_state_e state;
  svc_kind_e  kind;
  logic       take;
  logic       take_nmi;
  logic       bus_fire;
  logic       eval_en;

  assign eval_en   = boundary & ~busy;
  assign bus_valid = is_bus_state(state);
  assign bus_fire  = bus_valid & bus_ready;
  assign jam_clr   = done & (kind == SRC_RESET);

  int_pend_track #(
    .NSRC(NSRC), .NMI_BIT(NMI_BIT), .ONESHOT_MASK(ONESHOT_MASK)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .src_set(irq_set), .src_clr(irq_clr),
    .eval_en(eval_en), .i_prev(i_prev), .jammed(jammed),
    .line(irq_line), .take(take), .take_nmi(take_nmi)
  );

  int_seq_ctrl #(.SVC_CYCLES(SVC_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(take), .take_nmi(take_nmi),
    .bus_fire(bus_fire), .state(state), .kind(kind), .busy(busy), .done(done)
  );

  int_frame_path #(.STACK_PAGE(STACK_PAGE)) u_path (
    .clk(clk), .rst_n(rst_n), .state(state), .kind(kind), .capture(take),
    .bus_fire(bus_fire), .pc_in(pc_in), .p_in(p_in), .s_in(s_in),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pc_out(pc_out), .p_out(p_out), .s_out(s_out)
  );

  // R10: a refused request is held unchanged
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R1: end of reset leaves only the I flag set
  a_r1_reset_status: assert property (@(posedge clk) disable iff (!rst_n)
    jam_clr |-> (done && p_out == 8'h04));

  // R9: done lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_int_seq_top.sv
module tb_int_seq_top;

  localparam int NS = 4;
  localparam int NMIB = 3;
  localparam logic [NS-1:0] OS_MASK = 4'b0100;
  localparam int NVEC = 12;

  // {set[31:28], i_prev[27], jam[26], stall[25], take[24], nmi[23], line[22], 6'b0, s[15:8], p[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'b0, 8'hFD, 8'h00},
    {4'h4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b0, 8'h80, 8'h03},
    {4'h8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'b0, 8'h10, 8'h24},
    {4'h9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'b0, 8'h55, 8'hC4},
    {4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'b0, 8'h20, 8'h04},
    {4'h4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b0, 8'h20, 8'h04},
    {4'h2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'b0, 8'h20, 8'h00},
    {4'h8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'b0, 8'h20, 8'h00},
    {4'h2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'b0, 8'h01, 8'hFF},
    {4'h8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'b0, 8'h00, 8'h10},
    {4'h5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'b0, 8'h42, 8'h81},
    {4'hC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'b0, 8'h02, 8'h40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] irq_set = '0, irq_clr = '0;
  logic boundary = 1'b0, i_prev = 1'b0, jammed = 1'b0;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0] p_in = 8'h00, s_in = 8'h77;
  logic irq_line, busy, done, jam_clr;
  logic [15:0] pc_out;
  logic [7:0] p_out, s_out;
  logic bus_valid, bus_ready = 1'b1, bus_we;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memv(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  assign bus_rdata = memv(bus_addr);

  int_seq_top #(.NSRC(NS), .NMI_BIT(NMIB), .ONESHOT_MASK(OS_MASK)) dut (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .irq_clr(irq_clr),
    .boundary(boundary), .i_prev(i_prev), .jammed(jammed), .pc_in(pc_in),
    .p_in(p_in), .s_in(s_in), .irq_line(irq_line), .busy(busy), .done(done),
    .jam_clr(jam_clr), .pc_out(pc_out), .p_out(p_out), .s_out(s_out),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Serve one sequence from the current negedge on; kind: 0 reset, 1 NMI, 2 IRQ
  task automatic serve(input int kind, input logic [15:0] pc0, input logic [7:0] p0,
                       input logic [7:0] s0, input logic stall, input int exp_busy);
    logic [15:0] ea [5];
    logic        ew [5];
    logic [7:0]  ed [5];
    logic [15:0] base;
    logic [7:0]  pexp;
    int n, idx, bcnt;
    logic held, seen_done, jc;
    base = (kind == 0) ? 16'hFFFC : (kind == 1) ? 16'hFFFA : 16'hFFFE;
    if (kind == 0) begin
      n = 2;
      ea[0] = base; ew[0] = 1'b0; ed[0] = 8'h00;
      ea[1] = base + 16'd1; ew[1] = 1'b0; ed[1] = 8'h00;
    end else begin
      n = 5;
      ea[0] = {8'h01, s0};         ew[0] = 1'b1; ed[0] = pc0[15:8];
      ea[1] = {8'h01, s0 - 8'd1};  ew[1] = 1'b1; ed[1] = pc0[7:0];
      ea[2] = {8'h01, s0 - 8'd2};  ew[2] = 1'b1; ed[2] = (p0 & 8'hEF) | 8'h20;
      ea[3] = base;                ew[3] = 1'b0; ed[3] = 8'h00;
      ea[4] = base + 16'd1;        ew[4] = 1'b0; ed[4] = 8'h00;
    end
    idx = 0; bcnt = 0; held = 1'b0; seen_done = 1'b0; jc = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (done) begin seen_done = 1'b1; jc = jam_clr; break; end
      if (busy) bcnt++;
      if (bus_valid) begin
        if (idx < n) begin
          chk("R7/R8 bus address order", {16'h0, bus_addr}, {16'h0, ea[idx]});
          chk("R7/R8 bus direction", {31'h0, bus_we}, {31'h0, ew[idx]});
          if (ew[idx]) chk("R7 pushed byte", {24'h0, bus_wdata}, {24'h0, ed[idx]});
        end else begin
          chk("R9 extra bus request", 32'(idx), 32'(n - 1));
        end
        if (stall && !held) begin
          bus_ready = 1'b0; held = 1'b1;
        end else begin
          bus_ready = 1'b1; held = 1'b0; idx++;
        end
      end else begin
        bus_ready = 1'b1;
      end
      @(negedge clk);
    end
    bus_ready = 1'b1;
    chk("R9 done seen", {31'h0, seen_done}, 32'h1);
    chk("R9 all requests accepted", 32'(idx), 32'(n));
    if (exp_busy > 0) chk(stall ? "R10 stretched busy length" : "R9 busy length",
                          32'(bcnt), 32'(exp_busy));
    chk("R1 jam_clr with done", {31'h0, jc}, {31'h0, (kind == 0)});
    chk("R8 pc_out", {16'h0, pc_out}, {16'h0, memv(base + 16'd1), memv(base)});
    if (kind == 0) pexp = 8'h04;
    else if (kind == 1) pexp = p0 & 8'hEF;
    else pexp = (p0 & 8'hEF) | 8'h04;
    chk(kind == 0 ? "R1 p_out" : "R8 p_out", {24'h0, p_out}, {24'h0, pexp});
    chk(kind == 0 ? "R1 s_out" : "R7 s_out", {24'h0, s_out},
        {24'h0, (kind == 0) ? s_in : s0 - 8'd3});
    @(negedge clk);
    chk("R9 done single pulse", {31'h0, done}, 32'h0);
  endtask

  task automatic expect_idle(input string rq);
    for (int k = 0; k < 3; k++) begin
      chk(rq, {30'h0, busy, bus_valid}, 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic clear_all();
    irq_clr = '1;
    @(negedge clk);
    irq_clr = '0;
    @(negedge clk);
  endtask

  logic wd_hit = 1'b0;
  initial begin
    #(20 * 150000);
    wd_hit = 1'b1;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset sequence
    chk("R1 busy after reset", {31'h0, busy}, 32'h1);
    chk("R1 irq_line clear after reset", {31'h0, irq_line}, 32'h0);
    serve(0, 16'h0, 8'h0, 8'h0, 1'b0, 0);

    // R2: independent set and clear, OR line, no evaluation without boundary (R11)
    irq_set = 4'b0010; @(negedge clk); irq_set = '0;
    chk("R2 line on set", {31'h0, irq_line}, 32'h1);
    irq_set = 4'b0001; @(negedge clk); irq_set = '0;
    irq_clr = 4'b0010; @(negedge clk); irq_clr = '0;
    chk("R2 other bit keeps line", {31'h0, irq_line}, 32'h1);
    expect_idle("R11 no start without boundary");
    irq_clr = 4'b0001; @(negedge clk); irq_clr = '0;
    chk("R2 line drops when empty", {31'h0, irq_line}, 32'h0);
    boundary = 1'b1; @(negedge clk); boundary = 1'b0;
    expect_idle("R11 boundary with nothing pending");

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e;
      logic [15:0] pc0;
      e = VEC[v];
      pc0 = 16'h8000 ^ (16'(v) * 16'h0357);
      irq_set = e[31:28]; i_prev = e[27]; jammed = e[26];
      pc_in = pc0; s_in = e[15:8]; p_in = e[7:0];
      @(negedge clk);
      irq_set = '0; boundary = 1'b1;
      @(negedge clk);
      boundary = 1'b0;
      if (e[24]) begin
        chk(e[23] ? "R3 non-maskable start" : "R4 maskable start", {31'h0, busy}, 32'h1);
        serve(e[23] ? 1 : 2, pc0, e[7:0], e[15:8], e[25], e[25] ? 12 : 7);
      end else begin
        expect_idle(e[26] ? "R5 jammed blocks service" : "R4 masked request ignored");
      end
      chk("R6 pending after evaluation", {31'h0, irq_line}, {31'h0, e[22]});
      clear_all();
    end

    // R11: boundary during a sequence is ignored; the NMI waits for the next one
    i_prev = 1'b0; jammed = 1'b0; pc_in = 16'h1234; p_in = 8'h01; s_in = 8'hF0;
    irq_set = 4'b0001; @(negedge clk); irq_set = '0; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b1; irq_set = 4'b1000;
    @(negedge clk);
    boundary = 1'b0; irq_set = '0;
    serve(2, 16'h1234, 8'h01, 8'hF0, 1'b0, 6);
    chk("R11 NMI still pending after busy boundary", {31'h0, irq_line}, 32'h1);
    pc_in = 16'hBEEF; p_in = 8'h04; s_in = 8'hE0; i_prev = 1'b1;
    boundary = 1'b1; @(negedge clk); boundary = 1'b0;
    serve(1, 16'hBEEF, 8'h04, 8'hE0, 1'b0, 7);
    chk("R6 level bit kept after NMI", {31'h0, irq_line}, 32'h1);
    clear_all();

    if (!wd_hit) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule